// File: doc/BRIEF.md
# Register-Driven DDR Command Injector

This block lets a host drive a DDR SDRAM interface by hand, one register write at a time. It has two command phases, and each phase has its own registers for the row/column address, the bank and the write data. A write to a phase's command register produces a single one-cycle DRAM command on that phase's active-low control pins. The same write can also raise a write-data enable or a read-data enable. The pins return to NOP on every other cycle. A global control register holds the clock-enable pin. Firmware uses the block to run the power-up and mode-register sequence, and to make raw reads and writes before a real memory controller takes over.

The host port is a plain synchronous register port with word addressing. Phase `p` owns host addresses `32*p + offset`, and the global control register sits at host address 64. Read data returned by the memory with a valid strobe is held in eight byte registers per phase, where the host can read it back. The reset input is asynchronous. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_ni` rises.

Top module: `dfi_cmd_injector`

## Requirements
- R1: After reset, every `*_n` command pin is high, and `dfi_cke`, `dfi_wrdata_en`, `dfi_rddata_en`, `dfi_address` and `dfi_bank` are all zero. Every readable register reads 0.
- R2: Offset 1 (address high) holds address bits 12..5, and offset 2 (address low) holds bits 4..0. Phase p drives the 13-bit result on `dfi_address[13p +: 13]`.
- R3: Offset 3 holds the phase's bank, which is driven on `dfi_bank[3p +: 3]`.
- R4: A write to offset 0 (command) drives the pins for one cycle: bit0 drives CS, bit1 WE, bit2 CAS and bit3 RAS. A set bit drives that phase's active-low pin low during the cycle after the write edge only. In every cycle with no command write, all four pins are high.
- R5: The command values 0x0B (precharge), 0x0F (mode register load), 0x0D (auto refresh), 0x09 (activate), 0x05 (read) and 0x07 (write) give the matching pin patterns. The other phase stays at NOP.
- R6: Command bit4 (write data) raises `dfi_wrdata_en` of that phase for exactly one cycle, the cycle after the command cycle. `dfi_wrdata[64p + 8i +: 8]` carries write byte i, which is written at offset 8+i.
- R7: Command bit5 (read data) raises `dfi_rddata_en` of that phase in the command cycle. The first later cycle with that phase's `dfi_rddata_valid` high captures `dfi_rddata[64p +: 64]`, and byte i then reads back at offset 16+i.
- R8: A `dfi_rddata_valid` pulse with no read outstanding leaves the read bytes unchanged. Each read command arms exactly one capture.
- R9: Bit0 of the control register (host address 64) drives `dfi_cke`, and the pin holds its value until the register is written again.
- R10: Offsets 1, 2, 3, 8..15 and address 64 read back the last value written, zero-extended to 8 bits. Offset 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 7 | Host word address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, combinational from address |
| dfi_cke | output | 1 | Clock enable |
| dfi_cs_n | output | 2 | Chip select per phase, active low |
| dfi_ras_n | output | 2 | RAS per phase, active low |
| dfi_cas_n | output | 2 | CAS per phase, active low |
| dfi_we_n | output | 2 | WE per phase, active low |
| dfi_address | output | 26 | Row/column address, 13 bits per phase |
| dfi_bank | output | 6 | Bank address, 3 bits per phase |
| dfi_wrdata_en | output | 2 | Write data enable per phase |
| dfi_wrdata | output | 128 | Write data, 64 bits per phase |
| dfi_rddata_en | output | 2 | Read data enable per phase |
| dfi_rddata | input | 128 | Read data, 64 bits per phase |
| dfi_rddata_valid | input | 2 | Read data valid per phase |

## Verification
A command register that fails to self-clear leaves a pin low for a second cycle. This shows at the pins one cycle after the command. A write-enable delay stage that is missing or doubled moves `dfi_wrdata_en` by a cycle, and the bench catches that in the cycle right after the command. A bad arming flag for read capture shows only later, when the host reads the read bytes back after a valid pulse. The bench therefore reads them back after every valid pulse: before any read, after a read, and after a second unsolicited pulse.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;

  // Command register bit positions.
  localparam int CMD_W = 6;

  // Field order matches bit order: cs is bit0, rd is bit5.
  typedef struct packed {
    logic rd;
    logic wr;
    logic ras;
    logic cas;
    logic we;
    logic cs;
  } cmd_t;

  // Offsets inside one phase window.
  localparam logic [4:0] OFF_CMD  = 5'd0;
  localparam logic [4:0] OFF_AHI  = 5'd1;
  localparam logic [4:0] OFF_ALO  = 5'd2;
  localparam logic [4:0] OFF_BANK = 5'd3;
  localparam logic [1:0] GRP_WR   = 2'b01;
  localparam logic [1:0] GRP_RD   = 2'b10;

endpackage

// File: rtl/dfi_inj_rdcap.sv
module dfi_inj_rdcap #(
  parameter int BYTES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               valid_i,
  input  logic [BYTES*8-1:0] data_i,
  output logic [BYTES*8-1:0] data_o
);

  logic               pend_q, pend_d;
  logic [BYTES*8-1:0] data_q, data_d;
  logic               cap;

  assign cap = valid_i && pend_q;

  always_comb begin
    data_d = data_q;
    pend_d = pend_q;
    if (cap) begin
      data_d = data_i;
      pend_d = 1'b0;
    end
    if (arm_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (cap) data_q <= data_d;
    end
  end

  assign data_o = data_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

endmodule

// File: rtl/dfi_inj_phase.sv
module dfi_inj_phase
  import dfi_inj_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int ADDR_LO_W = 5,
  parameter int BANK_W    = 3,
  parameter int BYTES     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [4:0]         off_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               cs_n_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic [ADDR_W-1:0]  address_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic               wrdata_en_o,
  output logic [BYTES*8-1:0] wrdata_o,
  output logic               rddata_en_o,
  input  logic [BYTES*8-1:0] rddata_i,
  input  logic               rddata_valid_i
);

  localparam int AHI_W = ADDR_W - ADDR_LO_W;
  localparam int IDX_W = $clog2(BYTES);

  logic                        wsel, cmd_wr, ahi_en, alo_en, bank_en, wb_en;
  cmd_t                        cmd_q, cmd_d;
  logic                        wren_q;
  logic [AHI_W-1:0]            ahi_q, ahi_d;
  logic [ADDR_LO_W-1:0]        alo_q, alo_d;
  logic [BANK_W-1:0]           bank_q, bank_d;
  logic [BYTES-1:0][7:0]       wb_q, wb_d;
  logic [BYTES*8-1:0]          rbytes;
  logic [IDX_W-1:0]            idx;

  assign wsel    = sel_i && wr_i;
  assign idx     = off_i[IDX_W-1:0];
  assign cmd_wr  = wsel && (off_i == OFF_CMD);
  assign ahi_en  = wsel && (off_i == OFF_AHI);
  assign alo_en  = wsel && (off_i == OFF_ALO);
  assign bank_en = wsel && (off_i == OFF_BANK);
  assign wb_en   = wsel && (off_i[4:3] == GRP_WR);

  always_comb begin
    cmd_d   = cmd_wr ? cmd_t'(wdata_i[CMD_W-1:0]) : '0;
    ahi_d   = wdata_i[AHI_W-1:0];
    alo_d   = wdata_i[ADDR_LO_W-1:0];
    bank_d  = wdata_i[BANK_W-1:0];
    wb_d    = wb_q;
    wb_d[idx] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      wren_q <= 1'b0;
      ahi_q  <= '0;
      alo_q  <= '0;
      bank_q <= '0;
      wb_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      wren_q <= cmd_q.wr;
      if (ahi_en)  ahi_q  <= ahi_d;
      if (alo_en)  alo_q  <= alo_d;
      if (bank_en) bank_q <= bank_d;
      if (wb_en)   wb_q   <= wb_d;
    end
  end

  dfi_inj_rdcap #(.BYTES(BYTES)) u_rdcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (cmd_q.rd),
    .valid_i (rddata_valid_i),
    .data_i  (rddata_i),
    .data_o  (rbytes)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (off_i == OFF_AHI)            rdata_o = 8'(ahi_q);
    else if (off_i == OFF_ALO)       rdata_o = 8'(alo_q);
    else if (off_i == OFF_BANK)      rdata_o = 8'(bank_q);
    else if (off_i[4:3] == GRP_WR)   rdata_o = wb_q[idx];
    else if (off_i[4:3] == GRP_RD)   rdata_o = rbytes[idx*8 +: 8];
  end

  assign cs_n_o      = ~cmd_q.cs;
  assign ras_n_o     = ~cmd_q.ras;
  assign cas_n_o     = ~cmd_q.cas;
  assign we_n_o      = ~cmd_q.we;
  assign rddata_en_o = cmd_q.rd;
  assign wrdata_en_o = wren_q;
  assign address_o   = {ahi_q, alo_q};
  assign bank_o      = bank_q;
  assign wrdata_o    = wb_q;

  // R4
  nop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> (cs_n_o && ras_n_o && cas_n_o && we_n_o));

  // R6
  wren_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[4]) |=> ##1 wrdata_en_o);

  // R7
  rden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[5]) |=> rddata_en_o);

endmodule

// File: rtl/dfi_cmd_injector.sv
module dfi_cmd_injector #(
  parameter int PHASES    = 2,
  parameter int ADDR_W    = 13,
  parameter int ADDR_LO_W = 5,
  parameter int BANK_W    = 3,
  parameter int BYTES     = 8,
  parameter int HOST_AW   = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      host_wr_i,
  input  logic [HOST_AW-1:0]        host_addr_i,
  input  logic [7:0]                host_wdata_i,
  output logic [7:0]                host_rdata_o,
  output logic                      dfi_cke,
  output logic [PHASES-1:0]         dfi_cs_n,
  output logic [PHASES-1:0]         dfi_ras_n,
  output logic [PHASES-1:0]         dfi_cas_n,
  output logic [PHASES-1:0]         dfi_we_n,
  output logic [PHASES*ADDR_W-1:0]  dfi_address,
  output logic [PHASES*BANK_W-1:0]  dfi_bank,
  output logic [PHASES-1:0]         dfi_wrdata_en,
  output logic [PHASES*BYTES*8-1:0] dfi_wrdata,
  output logic [PHASES-1:0]         dfi_rddata_en,
  input  logic [PHASES*BYTES*8-1:0] dfi_rddata,
  input  logic [PHASES-1:0]         dfi_rddata_valid
);

  localparam int PH_W = HOST_AW - 6;
  localparam int DW   = BYTES * 8;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       ctl_sel, ctl_wr;
  logic       cke_q, cke_d;
  logic [PH_W-1:0] ph_idx;
  logic [7:0] ph_rdata [PHASES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign ctl_sel = host_addr_i[HOST_AW-1];
  assign ctl_wr  = host_wr_i && ctl_sel;
  assign ph_idx  = host_addr_i[5 +: PH_W];

  always_comb cke_d = host_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cke_q <= 1'b0;
    else if (ctl_wr) cke_q <= cke_d;
  end
  assign dfi_cke = cke_q;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic sel;
    assign sel = !ctl_sel && (ph_idx == PH_W'(p));

    dfi_inj_phase #(
      .ADDR_W(ADDR_W), .ADDR_LO_W(ADDR_LO_W), .BANK_W(BANK_W), .BYTES(BYTES)
    ) u_phase (
      .clk_i          (clk_i),
      .rst_ni         (rst_n),
      .sel_i          (sel),
      .wr_i           (host_wr_i),
      .off_i          (host_addr_i[4:0]),
      .wdata_i        (host_wdata_i),
      .rdata_o        (ph_rdata[p]),
      .cs_n_o         (dfi_cs_n[p]),
      .ras_n_o        (dfi_ras_n[p]),
      .cas_n_o        (dfi_cas_n[p]),
      .we_n_o         (dfi_we_n[p]),
      .address_o      (dfi_address[p*ADDR_W +: ADDR_W]),
      .bank_o         (dfi_bank[p*BANK_W +: BANK_W]),
      .wrdata_en_o    (dfi_wrdata_en[p]),
      .wrdata_o       (dfi_wrdata[p*DW +: DW]),
      .rddata_en_o    (dfi_rddata_en[p]),
      .rddata_i       (dfi_rddata[p*DW +: DW]),
      .rddata_valid_i (dfi_rddata_valid[p])
    );
  end

  always_comb begin
    host_rdata_o = 8'h00;
    if (ctl_sel) begin
      host_rdata_o = {7'b0, cke_q};
    end else begin
      for (int p = 0; p < PHASES; p++)
        if (ph_idx == PH_W'(p)) host_rdata_o = ph_rdata[p];
    end
  end

  // R9
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctl_wr |=> $stable(dfi_cke));

endmodule

// File: tb/sim_dfi_cmd_injector.sv
module sim_dfi_cmd_injector;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         host_wr = 1'b0;
  logic [6:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         dfi_cke;
  logic [1:0]   dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n;
  logic [25:0]  dfi_address;
  logic [5:0]   dfi_bank;
  logic [1:0]   dfi_wrdata_en, dfi_rddata_en;
  logic [127:0] dfi_wrdata;
  logic [127:0] dfi_rddata = '0;
  logic [1:0]   dfi_rddata_valid = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_ahi  [2];
  logic [4:0]  m_alo  [2];
  logic [2:0]  m_bank [2];
  logic [63:0] m_wb   [2];
  logic [63:0] m_rb   [2];

  always #5 clk = ~clk;

  dfi_cmd_injector u0 (
    .clk_i(clk), .rst_ni(rst_ni), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .dfi_cke(dfi_cke),
    .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n), .dfi_cas_n(dfi_cas_n),
    .dfi_we_n(dfi_we_n), .dfi_address(dfi_address), .dfi_bank(dfi_bank),
    .dfi_wrdata_en(dfi_wrdata_en), .dfi_wrdata(dfi_wrdata),
    .dfi_rddata_en(dfi_rddata_en), .dfi_rddata(dfi_rddata),
    .dfi_rddata_valid(dfi_rddata_valid)
  );

  function automatic logic [3:0] exp_pins(input logic [7:0] cmd);
    // {ras_n, cas_n, we_n, cs_n}
    return {~cmd[3], ~cmd[2], ~cmd[1], ~cmd[0]};
  endfunction

  function automatic logic [3:0] pins(input int p);
    return {dfi_ras_n[p], dfi_cas_n[p], dfi_we_n[p], dfi_cs_n[p]};
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; returns in the cycle after the write edge.
  task automatic hwrite(input logic [6:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [6:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  // Issue a command on phase p and check pins in the command cycle and the next one.
  task automatic issue(input string req, input int p, input logic [7:0] cmd);
    hwrite(7'(32*p), cmd);
    chk(req, "pins in command cycle", 128'(pins(p)), 128'(exp_pins(cmd)));
    chk("R5", "other phase NOP", 128'(pins(1-p)), 128'hF);
    chk("R7", "rddata_en in command cycle", 128'(dfi_rddata_en[p]), 128'(cmd[5]));
    chk("R6", "wrdata_en not early", 128'(dfi_wrdata_en[p]), 128'h0);
    @(negedge clk);
    chk("R4", "pins back to NOP", 128'({pins(1), pins(0)}), 128'hFF);
    chk("R6", "wrdata_en one cycle late", 128'(dfi_wrdata_en[p]), 128'(cmd[4]));
    chk("R7", "rddata_en one cycle", 128'(dfi_rddata_en[p]), 128'h0);
    @(negedge clk);
    chk("R6", "wrdata_en dropped", 128'(dfi_wrdata_en), 128'h0);
  endtask

  task automatic check_state(input int p);
    logic [7:0] r;
    chk("R2", "dfi_address", 128'(dfi_address[13*p +: 13]), 128'({m_ahi[p], m_alo[p]}));
    chk("R3", "dfi_bank", 128'(dfi_bank[3*p +: 3]), 128'(m_bank[p]));
    chk("R6", "dfi_wrdata", 128'(dfi_wrdata[64*p +: 64]), 128'(m_wb[p]));
    hread(7'(32*p + 1), r); chk("R10", "readback ahi", 128'(r), 128'(m_ahi[p]));
    hread(7'(32*p + 2), r); chk("R10", "readback alo", 128'(r), 128'(m_alo[p]));
    hread(7'(32*p + 3), r); chk("R10", "readback bank", 128'(r), 128'(m_bank[p]));
    hread(7'(32*p),     r); chk("R10", "command reads zero", 128'(r), 128'h0);
  endtask

  task automatic check_rbytes(input string req, input int p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      hread(7'(32*p + 16 + i), r);
      chk(req, "read byte", 128'(r), 128'(m_rb[p][8*i +: 8]));
    end
  endtask

  task automatic pulse_valid(input int p, input logic [63:0] d);
    dfi_rddata[64*p +: 64] = d;
    dfi_rddata_valid[p] = 1'b1;
    @(negedge clk);
    dfi_rddata_valid[p] = 1'b0;
    dfi_rddata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    report();
  end

  initial begin
    logic [7:0] r;
    logic [7:0] cmds [6];
    void'($urandom(32'd20240611));
    for (int p = 0; p < 2; p++) begin
      m_ahi[p] = '0; m_alo[p] = '0; m_bank[p] = '0; m_wb[p] = '0; m_rb[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "pins", 128'({pins(1), pins(0)}), 128'hFF);
    chk("R1", "cke", 128'(dfi_cke), 128'h0);
    chk("R1", "enables", 128'({dfi_wrdata_en, dfi_rddata_en}), 128'h0);
    chk("R1", "address/bank", 128'({dfi_address, dfi_bank}), 128'h0);
    chk("R1", "wrdata", dfi_wrdata, 128'h0);
    for (int p = 0; p < 2; p++) check_state(p);
    check_rbytes("R1", 0);

    // R9 clock enable
    hwrite(7'd64, 8'h01);
    chk("R9", "cke set", 128'(dfi_cke), 128'h1);
    repeat (5) @(negedge clk);
    chk("R9", "cke held", 128'(dfi_cke), 128'h1);
    hread(7'd64, r); chk("R10", "control readback", 128'(r), 128'h1);

    // R2/R3 address split and bank, directed corner: all ones
    hwrite(7'd1, 8'hFF); m_ahi[0] = 8'hFF;
    hwrite(7'd2, 8'hFF); m_alo[0] = 5'h1F;
    hwrite(7'd3, 8'hFF); m_bank[0] = 3'h7;
    check_state(0);
    check_state(1);
    hwrite(7'd1, 8'h09); m_ahi[0] = 8'h09;
    hwrite(7'd2, 8'h12); m_alo[0] = 5'h12;
    hwrite(7'd3, 8'h01); m_bank[0] = 3'h1;
    check_state(0);

    // R5 the six DRAM commands, alternating phases
    cmds[0] = 8'h0B; cmds[1] = 8'h0F; cmds[2] = 8'h0D;
    cmds[3] = 8'h09; cmds[4] = 8'h05; cmds[5] = 8'h07;
    for (int k = 0; k < 6; k++) issue("R5", k % 2, cmds[k]);

    // R6 write data on phase 1
    for (int i = 0; i < 8; i++) begin
      hwrite(7'(32 + 8 + i), 8'(8'hF0 + i));
      m_wb[1][8*i +: 8] = 8'(8'hF0 + i);
    end
    check_state(1);
    issue("R6", 1, 8'h17);

    // R8 valid with no read outstanding
    pulse_valid(0, 64'hDEAD_BEEF_0123_4567);
    check_rbytes("R8", 0);

    // R7 read on phase 0, capture after a gap
    issue("R7", 0, 8'h25);
    @(negedge clk);
    pulse_valid(0, 64'h8877_6655_4433_2211);
    m_rb[0] = 64'h8877_6655_4433_2211;
    check_rbytes("R7", 0);
    // R8 second pulse after capture is ignored
    pulse_valid(0, 64'h0102_0304_0506_0708);
    check_rbytes("R8", 0);
    check_rbytes("R8", 1);

    // R4 back-to-back commands give two command cycles
    hwrite(7'd0, 8'h09);
    chk("R4", "first of pair", 128'(pins(0)), 128'(exp_pins(8'h09)));
    hwrite(7'd0, 8'h05);
    chk("R4", "second of pair", 128'(pins(0)), 128'(exp_pins(8'h05)));
    @(negedge clk);
    chk("R4", "pair done", 128'(pins(0)), 128'hF);

    // Random mix of register writes and commands
    for (int n = 0; n < 40; n++) begin
      int p;
      logic [7:0] v;
      int bi;
      p = int'($urandom % 2);
      v = 8'($urandom);
      hwrite(7'(32*p + 1), v); m_ahi[p] = v;
      v = 8'($urandom);
      hwrite(7'(32*p + 2), v); m_alo[p] = v[4:0];
      v = 8'($urandom);
      hwrite(7'(32*p + 3), v); m_bank[p] = v[2:0];
      bi = int'($urandom % 8);
      v = 8'($urandom);
      hwrite(7'(32*p + 8 + bi), v); m_wb[p][8*bi +: 8] = v;
      check_state(p);
      v = 8'($urandom) & 8'h1F;
      issue("R4", p, v);
    end

    // R9 clear clock enable
    hwrite(7'd64, 8'hFE);
    chk("R9", "cke cleared", 128'(dfi_cke), 128'h0);
    repeat (3) @(negedge clk);
    chk("R9", "cke stays low", 128'(dfi_cke), 128'h0);

    report();
  end

endmodule